// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Buffer

This block is the receive side of an isochronous OUT endpoint in a USB device controller. The packet engine on the USB side delivers a packet as a start strobe, a run of byte strobes, and an end strobe that carries the result of the CRC check. The block writes the bytes into one of two packet buffers used in ping-pong fashion. A packet that checks good is committed. A packet that fails the check is thrown away, and its buffer goes back to empty.

A processor reaches the block through a small register port. One register gives status: the receive-service flag and a sticky overrun bit. A second register gives the byte count of the packet at the head. A third is the data port, and each read of it pops one byte from the head packet. Packets come out in the order they arrived. The service flag rises only once a whole packet has passed the error check. It then stays high until every byte held in both buffers has been read out. Full-size packets, short packets and zero-length packets all count as complete.

Top module: `iso_out_rx`

## Requirements
- R1: After reset, the status register (address 0), the count register (address 1) and the data port (address 2) all read 0.
- R2: A packet closed by rx_end with rx_crc_ok=1 sets status bit 0 (service) from the next cycle. The count register then reads its length, for any length from 0 up to MAX_PKT.
- R3: Each read strobe at address 2 returns the next byte of the head packet, in the order the bytes were received. Reading the last byte releases that buffer.
- R4: The service bit stays 1 while either buffer still holds an unread packet. It goes to 0 only once both buffers are empty.
- R5: A packet closed with rx_crc_ok=0 is discarded. The service bit, the count and the packets already buffered are unchanged, and the buffer can take the next packet.
- R6: A start strobe that arrives while both buffers are full drops that packet and sets status bit 1 (overrun). The two stored packets are kept intact.
- R7: The overrun bit stays set until the processor writes a 1 to bit 1 of address 0. Writing 0 to that bit leaves it set.
- R8: When two packets are buffered, the processor reads them in arrival order, and the count register follows the head packet.
- R9: A zero-length packet occupies a buffer with count 0 and sets the service bit. A read strobe at address 1 that sees count 0 releases the buffer.
- R10: Bytes beyond MAX_PKT in one packet are discarded, and the committed count is MAX_PKT.
- R11: Status bits 2 and up and address 3 read 0. Writes to address 0 other than bit 1, and writes to any other address, have no effect.
- R12: A data read while no packet is buffered returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Start of an incoming packet |
| rx_valid | input | 1 | rx_data holds a packet byte |
| rx_data | input | 8 | Packet byte |
| rx_end | input | 1 | End of packet, may accompany the last byte |
| rx_crc_ok | input | 1 | Qualifies rx_end: 1 means the packet passed CRC |
| cpu_addr | input | 2 | Register select: 0 status, 1 count, 2 data, 3 reserved |
| cpu_rd | input | 1 | Read strobe; pops a byte at address 2, releases an empty packet at address 1 |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | REG_W | Write data |
| cpu_rdata | output | REG_W | Read data, combinational from cpu_addr |

## Verification
The bench builds the block with MAX_PKT=8 and REG_W=16. At that size it can sweep every packet length from 0 to 8, and every pair of lengths queued back to back in the two buffers, so the full-size, short and zero-length cases all meet both buffer positions and both drain orders. An oversize packet, a CRC-failed packet sent with and without a packet already held, and a third packet sent into two full buffers cover the drop paths. Register writes with mixed bit patterns exercise the sticky overrun bit and the ignored fields.

// File: rtl/iso_out_rx.sv
module iso_out_rx #(
  parameter int MAX_PKT = 256,
  parameter int REG_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_end,
  input  logic             rx_crc_ok,
  input  logic [1:0]       cpu_addr,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata
);
  localparam int CW = $clog2(MAX_PKT + 1);
  localparam int IW = $clog2(2 * MAX_PKT);
  localparam logic [CW-1:0] MAXC = CW'(MAX_PKT);
  localparam logic [IW-1:0] HALF = IW'(MAX_PKT);

  logic [7:0]    mem [2*MAX_PKT];
  logic [1:0]    full, full_n;
  logic [CW-1:0] len [2];
  logic          head, tail, rxing, ovr;
  logic [CW-1:0] wcnt, rptr;

  logic          unused_w;
  assign unused_w = ^{cpu_wdata[REG_W-1:2], cpu_wdata[0]};

  wire           wr_byte = rxing && rx_valid && (wcnt < MAXC);
  wire [CW-1:0]  cnt_fin = wcnt + CW'(wr_byte);
  wire           commit  = !rx_start && rxing && rx_end && rx_crc_ok;
  wire [CW-1:0]  hlen    = len[head];
  wire           rd_data = cpu_rd && cpu_addr == 2'd2 && full[head] && hlen != '0;
  wire           rd_last = rd_data && (rptr + 1'b1 == hlen);
  wire           rd_zero = cpu_rd && cpu_addr == 2'd1 && full[head] && hlen == '0;
  wire           release_h = rd_last || rd_zero;
  wire           svc     = |full;
  wire           ovr_clr = cpu_wr && cpu_addr == 2'd0 && cpu_wdata[1];
  wire           drop    = rx_start && full[tail];

  wire [IW-1:0]  widx = (tail ? HALF : '0) + IW'(wcnt);
  wire [IW-1:0]  ridx = (head ? HALF : '0) + IW'(rptr);

  always_ff @(posedge clk)
    if (wr_byte) mem[widx] <= rx_data;

  always_comb begin
    full_n = full;
    if (commit)    full_n[tail] = 1'b1;
    if (release_h) full_n[head] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= '0;
      len   <= '{default: '0};
      head  <= 1'b0;
      tail  <= 1'b0;
      rxing <= 1'b0;
      wcnt  <= '0;
      rptr  <= '0;
      ovr   <= 1'b0;
    end else begin
      full <= full_n;
      if (rx_start) begin
        rxing <= !full[tail];
        wcnt  <= '0;
      end else if (rxing) begin
        if (wr_byte) wcnt <= wcnt + 1'b1;
        if (rx_end) begin
          rxing <= 1'b0;
          if (rx_crc_ok) begin
            len[tail] <= cnt_fin;
            tail      <= ~tail;
          end
        end
      end
      if (release_h) begin
        head <= ~head;
        rptr <= '0;
      end else if (rd_data) begin
        rptr <= rptr + 1'b1;
      end
      if (ovr_clr) ovr <= 1'b0;
      if (drop)    ovr <= 1'b1;
    end
  end

  always_comb begin
    case (cpu_addr)
      2'd0:    cpu_rdata = REG_W'({ovr, svc});
      2'd1:    cpu_rdata = full[head] ? REG_W'(hlen) : '0;
      2'd2:    cpu_rdata = (full[head] && hlen != '0) ? REG_W'(mem[ridx]) : '0;
      default: cpu_rdata = '0;
    endcase
  end

  assert_bad_crc_no_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxing && !rx_start && rx_end && !rx_crc_ok) |=> ($countones(full) <= $past($countones(full))));

  assert_drop_sets_ovr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && full[tail]) |=> (ovr && !rxing));

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);

  assert_rptr_in_pkt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full[head] && hlen != '0) |-> (rptr < hlen));

  assert_wcnt_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= MAXC);

  for (genvar b = 0; b < 2; b++) begin : g_chk
    assert_len_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      full[b] |-> (len[b] <= MAXC));
  end
endmodule

// File: tb/iso_out_rx_test.sv
`timescale 1ns/1ps
module iso_out_rx_test;
  localparam int MAXP = 8;
  localparam int RW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_start = 0, rx_valid = 0, rx_end = 0, rx_crc_ok = 0;
  logic [7:0] rx_data = '0;
  logic [1:0] cpu_addr = '0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [RW-1:0] cpu_wdata = '0;
  logic [RW-1:0] cpu_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  iso_out_rx #(.MAX_PKT(MAXP), .REG_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 v = int'(cpu_rdata);
    @(posedge clk);
    #1 cpu_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    @(negedge clk);
    cpu_addr = a;
    #1 v = int'(cpu_rdata);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b1; cpu_wdata = RW'(d);
    @(posedge clk);
    #1 cpu_wr = 1'b0;
  endtask

  task automatic send(input int n, input int base, input bit good);
    @(negedge clk);
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = 8'(base + i);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_end = 1'b1; rx_crc_ok = good;
    @(negedge clk);
    rx_end = 1'b0; rx_crc_ok = 1'b0;
  endtask

  task automatic drain(input int n, input int base, input string req);
    int v;
    int k;
    k = (n > MAXP) ? MAXP : n;
    peek(2'd1, v); chk({req, " count"}, v, k);
    if (k == 0) rd(2'd1, v);
    for (int i = 0; i < k; i++) begin
      rd(2'd2, v); chk({req, " byte"}, v, (base + i) & 8'hFF);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    peek(2'd0, v); chk("R1 status", v, 0);
    peek(2'd1, v); chk("R1 count", v, 0);
    peek(2'd2, v); chk("R1 data", v, 0);

    rd(2'd2, v); chk("R12 empty data", v, 0);
    peek(2'd0, v); chk("R12 status after empty read", v, 0);

    for (int n = 0; n <= MAXP; n++) begin
      send(n, n * 16, 1'b1);
      peek(2'd0, v); chk("R2 svc after packet", v, 1);
      drain(n, n * 16, n == 0 ? "R9" : "R2 R3");
      peek(2'd0, v); chk("R4 svc clears when drained", v, 0);
    end

    for (int a = 0; a <= MAXP; a++)
      for (int b = 0; b <= MAXP; b++) begin
        send(a, 8'h40 + a, 1'b1);
        send(b, 8'h80 + b, 1'b1);
        drain(a, 8'h40 + a, "R8 first");
        peek(2'd0, v); chk("R4 svc held by second", v, 1);
        drain(b, 8'h80 + b, "R8 second");
        peek(2'd0, v); chk("R4 svc after both", v, 0);
      end

    send(MAXP + 3, 8'hA0, 1'b1);
    drain(MAXP + 3, 8'hA0, "R10");

    send(5, 8'h10, 1'b0);
    peek(2'd0, v); chk("R5 bad alone status", v, 0);
    peek(2'd1, v); chk("R5 bad alone count", v, 0);
    send(3, 8'h20, 1'b1);
    send(6, 8'h30, 1'b0);
    peek(2'd0, v); chk("R5 svc unchanged", v, 1);
    send(2, 8'h50, 1'b1);
    drain(3, 8'h20, "R5 kept");
    drain(2, 8'h50, "R5 reuse");
    peek(2'd0, v); chk("R5 drained", v, 0);

    send(4, 8'h60, 1'b1);
    send(MAXP, 8'h70, 1'b1);
    send(2, 8'hE0, 1'b1);
    peek(2'd0, v); chk("R6 overrun set", v, 3);
    wr(2'd0, 16'h0001);
    peek(2'd0, v); chk("R7 write 0 keeps overrun", v, 3);
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'hFFFF);
    peek(2'd0, v); chk("R11 other writes ignored", v, 3);
    drain(4, 8'h60, "R6 first kept");
    drain(MAXP, 8'h70, "R6 second kept");
    peek(2'd0, v); chk("R6 dropped not stored", v, 2);
    wr(2'd0, 16'hFFFF);
    peek(2'd0, v); chk("R7 write 1 clears", v, 0);
    peek(2'd3, v); chk("R11 addr3 zero", v, 0);

    send(1, 8'h5A, 1'b1);
    wr(2'd0, 16'hFFFD);
    peek(2'd0, v); chk("R11 svc not writable", v, 1);
    drain(1, 8'h5A, "R11 packet intact");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule